// File: doc/BRIEF.md
# Frame-Synchronized FIFO Clear Controller

This block decides when the two FIFOs of a camera capture path are reset. One is the pixel receive FIFO and the other is the statistics FIFO. Software uses a small write port to set a policy bit and two per-FIFO clear-request bits. The block turns these into reset signals for the two FIFOs. Under the immediate policy, a request resets its FIFO for one cycle at once. Under the frame-synchronized policy, the reset is tied to the start-of-frame pulse, so a FIFO never loses half a frame.

The frame-synchronized policy can be built in one of two ways, chosen by a build parameter:
- **Arm-on-SOF:** a request arms the FIFO, and the next start-of-frame delivers a single reset pulse.
- **Hold-till-SOF:** a request puts the FIFO into reset at once and keeps it there until the next start-of-frame releases it.

In both variants, a serviced request bit returns to 0 by itself. Software must set it again to clear the next frame.

Top module: `frame_fifo_clear`

## Requirements
- R1: While the synchronous reset `rst` is sampled high, both FIFO reset outputs are 1 and the policy and request readbacks are 0.
- R2: A write (`wr_en`=1) stores `wr_sync_mode`, and `rd_sync_mode` shows it from the next cycle. Value 1 selects the frame-synchronized policy and value 0 selects the immediate policy.
- R3: A write with `wr_sync_mode`=0 and a request bit of 1 gives that FIFO's reset output a pulse of exactly one cycle, starting the next cycle. The request readback for that FIFO stays 0.
- R4: The pixel lane (request bit `wr_clr_pix`) and the statistics lane (`wr_clr_stat`) act independently. A request on one never changes the reset output or readback of the other.
- R5: Arm-on-SOF: a write with `wr_sync_mode`=1 and a request bit of 1 sets that readback to 1 from the next cycle, with no reset yet.
- R6: Arm-on-SOF: when `sof` is sampled high while a lane is armed, that lane's reset output is 1 for exactly the next cycle, and its readback returns to 0 in that same cycle.
- R7: Hold-till-SOF: a write with `wr_sync_mode`=1 and a request bit of 1 sets that lane's reset output and readback to 1 from the next cycle. Both stay 1 while no `sof` arrives.
- R8: Hold-till-SOF: when `sof` is sampled high while a lane is held, its reset output and readback both drop to 0 the next cycle.
- R9: If a frame-synchronized request and `sof` arrive in the same cycle, the request stays pending (readback 1) and is served by the following `sof`. Any clear that was already pending is still served by the current `sof`.
- R10: A write whose request bit is 0 leaves that lane's pending request and reset output unchanged.
- R11: A `sof` pulse with no pending request produces no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_sync_mode | input | 1 | Policy bit written: 1 frame-synchronized, 0 immediate |
| wr_clr_pix | input | 1 | Clear request for the pixel FIFO |
| wr_clr_stat | input | 1 | Clear request for the statistics FIFO |
| sof | input | 1 | Start-of-frame pulse, one cycle |
| pix_fifo_rst | output | 1 | Reset to the pixel FIFO |
| stat_fifo_rst | output | 1 | Reset to the statistics FIFO |
| rd_sync_mode | output | 1 | Readback of the policy bit |
| rd_clr_pix | output | 1 | Readback of the pixel clear request |
| rd_clr_stat | output | 1 | Readback of the statistics clear request |

## Verification
The hardest case to reach is a request write that lands in the same cycle as `sof`. It is harder still when a clear for that lane is already pending. In that case the current frame must be cleared while the new request stays pending for the next one. The stimulus arms a lane, then issues a second request together with `sof`. It checks that a reset is issued, that the readback stays 1, and that one further `sof` completes the cycle. Both variants receive the same stimulus in parallel, so each is checked against its own expected values.

// File: rtl/fclr_pkg.sv
package fclr_pkg;

    typedef enum logic {
        VAR_ARM_ON_SOF    = 1'b0,
        VAR_HOLD_TILL_SOF = 1'b1
    } clr_variant_e;

    localparam int NUM_LANES = 2;
    localparam int LANE_PIX  = 0;
    localparam int LANE_STAT = 1;

    typedef struct packed {
        logic                 sync_mode;
        logic [NUM_LANES-1:0] req;
    } ctrl_wr_t;

    // Next pending-request state of one lane.
    function automatic logic lane_next_req(input logic cur, input logic sync_set,
                                           input logic async_set, input logic fire);
        if (sync_set)
            return 1'b1;
        else if (async_set || fire)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/fclr_mode_reg.sv
module fclr_mode_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_mode,
    output logic mode_q,
    output logic mode_eff
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 1'b0;
        else if (wr_en)
            mode_q <= wr_mode;
    end

    // The policy travelling with a write governs the requests in that write.
    assign mode_eff = wr_en ? wr_mode : mode_q;

    AST_MODE_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mode_q == $past(wr_mode)));  // R2

endmodule

// File: rtl/fclr_lane.sv
module fclr_lane
    import fclr_pkg::*;
#(
    parameter clr_variant_e VARIANT = VAR_ARM_ON_SOF
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic sync_mode,
    input  logic sof,
    output logic fifo_rst,
    output logic req_rd
);

    logic req_q;
    logic pulse_q;
    logic sync_set;
    logic async_set;
    logic fire;

    assign sync_set  = set_req & sync_mode;
    assign async_set = set_req & ~sync_mode;
    assign fire      = sof & req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= lane_next_req(req_q, sync_set, async_set, fire);
        end
    end

    generate
        if (VARIANT == VAR_ARM_ON_SOF) begin : g_arm
            always_ff @(posedge clk) begin
                if (rst)
                    pulse_q <= 1'b1;
                else
                    pulse_q <= async_set | fire;
            end
            assign fifo_rst = pulse_q;

            AST_ARM_FIRE: assert property (@(posedge clk) disable iff (rst)
                (fire && !async_set) |=> fifo_rst);  // R6
            AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
                $fell(req_q) |-> fifo_rst);  // R6
        end else begin : g_hold
            always_ff @(posedge clk) begin
                if (rst)
                    pulse_q <= 1'b1;
                else
                    pulse_q <= async_set;
            end
            assign fifo_rst = pulse_q | req_q;

            AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
                (fire && !set_req) |=> !req_q);  // R8
        end
    endgenerate

    assign req_rd = req_q;

    AST_IMMEDIATE_PULSE: assert property (@(posedge clk) disable iff (rst)
        async_set |=> (fifo_rst && !req_rd));  // R3
    AST_SYNC_PENDING: assert property (@(posedge clk) disable iff (rst)
        sync_set |=> req_rd);  // R9
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !sof) |=> $stable(req_q));  // R10

endmodule

// File: rtl/frame_fifo_clear.sv
module frame_fifo_clear
    import fclr_pkg::*;
#(
    parameter clr_variant_e VARIANT = VAR_ARM_ON_SOF
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_sync_mode,
    input  logic wr_clr_pix,
    input  logic wr_clr_stat,
    input  logic sof,
    output logic pix_fifo_rst,
    output logic stat_fifo_rst,
    output logic rd_sync_mode,
    output logic rd_clr_pix,
    output logic rd_clr_stat
);

    ctrl_wr_t             wr_word;
    logic                 mode_q;
    logic                 mode_eff;
    logic [NUM_LANES-1:0] lane_rst;
    logic [NUM_LANES-1:0] lane_req;

    always_comb begin
        wr_word.sync_mode           = wr_sync_mode;
        wr_word.req                 = '0;
        wr_word.req[LANE_PIX]       = wr_clr_pix;
        wr_word.req[LANE_STAT]      = wr_clr_stat;
    end

    fclr_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_mode  (wr_word.sync_mode),
        .mode_q   (mode_q),
        .mode_eff (mode_eff)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        fclr_lane #(.VARIANT(VARIANT)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .set_req   (wr_en & wr_word.req[i]),
            .sync_mode (mode_eff),
            .sof       (sof),
            .fifo_rst  (lane_rst[i]),
            .req_rd    (lane_req[i])
        );
    end

    assign pix_fifo_rst  = lane_rst[LANE_PIX];
    assign stat_fifo_rst = lane_rst[LANE_STAT];
    assign rd_clr_pix    = lane_req[LANE_PIX];
    assign rd_clr_stat   = lane_req[LANE_STAT];
    assign rd_sync_mode  = mode_q;

    AST_LANE_ISOLATION: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_clr_stat && !sof) |=> $stable(rd_clr_stat));  // R4

endmodule

// File: tb/frame_fifo_clear_test.sv
module frame_fifo_clear_test;
    import fclr_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic wr_en, wr_sync_mode, wr_clr_pix, wr_clr_stat, sof;
    logic a_pix_rst, a_stat_rst, a_mode, a_rd_pix, a_rd_stat;
    logic h_pix_rst, h_stat_rst, h_mode, h_rd_pix, h_rd_stat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    frame_fifo_clear #(.VARIANT(VAR_ARM_ON_SOF)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sync_mode(wr_sync_mode),
        .wr_clr_pix(wr_clr_pix), .wr_clr_stat(wr_clr_stat), .sof(sof),
        .pix_fifo_rst(a_pix_rst), .stat_fifo_rst(a_stat_rst),
        .rd_sync_mode(a_mode), .rd_clr_pix(a_rd_pix), .rd_clr_stat(a_rd_stat)
    );

    frame_fifo_clear #(.VARIANT(VAR_HOLD_TILL_SOF)) uut_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sync_mode(wr_sync_mode),
        .wr_clr_pix(wr_clr_pix), .wr_clr_stat(wr_clr_stat), .sof(sof),
        .pix_fifo_rst(h_pix_rst), .stat_fifo_rst(h_stat_rst),
        .rd_sync_mode(h_mode), .rd_clr_pix(h_rd_pix), .rd_clr_stat(h_rd_stat)
    );

    // Row: wr mode pix stat sof | arm: rst_pix rst_stat rd_pix rd_stat |
    //      hold: rst_pix rst_stat rd_pix rd_stat | mode
    localparam int NSTEP = 15;
    localparam logic [13:0] STEPS [NSTEP] = '{
        14'b00000_0000_0000_0,  //  0 idle, R11 baseline
        14'b11100_0010_1010_1,  //  1 sync pix request: R5 arm, R7 hold
        14'b00001_1000_0000_1,  //  2 sof: R6 pulse, R8 release
        14'b00000_0000_0000_1,  //  3 pulse lasts one cycle, R6
        14'b00001_0000_0000_1,  //  4 sof with nothing pending, R11
        14'b11011_0001_0101_1,  //  5 stat request with sof same cycle, R9
        14'b00001_0100_0000_1,  //  6 following sof serves it, R9
        14'b11110_0011_1111_1,  //  7 both lanes, R4
        14'b11000_0011_1111_1,  //  8 write of zero bits, R10
        14'b00001_1100_0000_1,  //  9 sof serves both, R4
        14'b10100_1000_1000_0,  // 10 immediate pix request, R3
        14'b00000_0000_0000_0,  // 11 immediate pulse ends, R3
        14'b11100_0010_1010_1,  // 12 pending again, R2 mode back to 1
        14'b11101_1010_1010_1,  // 13 rerequest with sof while pending, R9
        14'b00001_1000_0000_1   // 14 final sof, R6 / R8
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 4:        return "R11";
            1:           return "R5/R7";
            2, 14:       return "R6/R8";
            3:           return "R6";
            5, 6, 13:    return "R9";
            7, 9:        return "R4";
            8:           return "R10";
            10, 11:      return "R3";
            default:     return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic m, input logic p, input logic s, input logic f);
        wr_en = w; wr_sync_mode = m; wr_clr_pix = p; wr_clr_stat = s; sof = f;
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1", "arm pix_rst", a_pix_rst, 1'b1);
        check("R1", "arm stat_rst", a_stat_rst, 1'b1);
        check("R1", "hold pix_rst", h_pix_rst, 1'b1);
        check("R1", "hold stat_rst", h_stat_rst, 1'b1);
        check("R1", "mode", a_mode, 1'b0);
        check("R1", "rd_pix", a_rd_pix | h_rd_pix, 1'b0);
        check("R1", "rd_stat", a_rd_stat | h_rd_stat, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NSTEP; i++) begin
            logic [13:0] v;
            string t;
            v = STEPS[i];
            t = tag_of(i);
            drive(v[13], v[12], v[11], v[10], v[9]);
            @(negedge clk);
            check(t, "arm pix_rst", a_pix_rst, v[8]);
            check(t, "arm stat_rst", a_stat_rst, v[7]);
            check(t, "arm rd_pix", a_rd_pix, v[6]);
            check(t, "arm rd_stat", a_rd_stat, v[5]);
            check(t, "hold pix_rst", h_pix_rst, v[4]);
            check(t, "hold stat_rst", h_stat_rst, v[3]);
            check(t, "hold rd_pix", h_rd_pix, v[2]);
            check(t, "hold rd_stat", h_rd_stat, v[1]);
            check("R2", "mode", a_mode, v[0]);
            check("R2", "hold mode", h_mode, v[0]);
        end

        // R7: hold persists over several idle cycles
        drive(1, 1, 1, 0, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        check("R7", "hold pix_rst held", h_pix_rst, 1'b1);
        check("R5", "arm pix_rst idle", a_pix_rst, 1'b0);
        check("R5", "arm rd_pix pending", a_rd_pix, 1'b1);

        // R1: reset in mid-run drops pending requests and policy
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "arm rd_pix after rst", a_rd_pix, 1'b0);
        check("R1", "hold rd_pix after rst", h_rd_pix, 1'b0);
        check("R1", "mode after rst", a_mode, 1'b0);
        check("R1", "arm stat_rst in rst", a_stat_rst, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        drive(0, 0, 0, 0, 1);
        @(negedge clk);
        check("R11", "arm pix_rst after rst+sof", a_pix_rst, 1'b0);
        check("R11", "hold pix_rst after rst+sof", h_pix_rst, 1'b0);
        drive(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule